// File: doc/BRIEF.md
# Key-Protected Low-Speed Tick Selector

This block builds the slow timekeeping clocks of a chip as single-cycle clock-enable pulses on one fast system clock. Each source arrives as a one-cycle strobe on that clock: a strobe for every cycle of the internal 16 MHz RC oscillator, one for the external 32 kHz crystal, one for the 24 MHz reference, and one for an alternate 32 kHz input such as a calibrated source. From these strobes the block derives five strobes:

- an internal low-speed tick, made by dividing the RC strobes by 32 and then by a programmable (N+1);
- a gated copy of the crystal strobe;
- a tick made by dividing the reference strobes by 750;
- a selected real-time tick;
- a gated fanout tick that can take one of several sources.

Software sets up the block through a 32-bit register port. Writes take effect on the clock edge. Reads are combinational on the address. The main control word changes only when the write carries a 16-bit key in its upper half. This guards the real-time clock source against stray writes.

Each divider stage is a two-state machine. The states are `DIV_IDLE` and `DIV_RUN`.

- In `DIV_IDLE` the stage holds its counter at zero, keeps its output low and keeps copying its limit.
- The transition *start* (enable seen high) moves the stage to `DIV_RUN`. There it counts input strobes.
- At the terminal count it emits a registered pulse, restarts from zero and takes a fresh copy of its limit.
- The transition *stop* (enable seen low) returns the stage to `DIV_IDLE`.

Top module: `lsclk_sel`

Register map. Offsets are byte addresses on `addr`. All registers reset to zero.

| Offset | Bits used | Meaning |
|--------|-----------|---------|
| 0x000 | [0], [1], [4] | Control word (key-protected) |
| 0x008 | [4:0] | Divider field N |
| 0x060 | [0], [2:1], [16] | Fanout enable, fanout source select, reference-tick gate |
| 0x160 | [0] | RC source enable |

Control word at offset 0x000:
- Bit 0 = 0: the oscillator tick is the internal tick.
- Bit 0 = 1: the oscillator tick is the gated crystal strobe.
- Bit 1 = 0: the real-time tick follows the oscillator tick.
- Bit 1 = 1: the real-time tick follows the reference tick.
- Bit 4 = 1: the crystal strobe passes to the gated crystal output.

Fanout source select, bits [2:1] at offset 0x060:
- 0: oscillator tick
- 1: alternate input
- 2: reference tick
- 3: held low

## Requirements
- R1: After reset every register reads zero, the RC source is disabled and every output tick stays low.
- R2: A write to offset 0x000 updates the control word only when wdata[31:16] equals 0x16AA. Any other write there leaves the readback unchanged.
- R3: Reading offset 0x000 returns the stored control bits in [15:0], with [31:16] reading zero.
- R4: With the RC source enabled (offset 0x160 bit 0), `iosc32_tick` pulses once per 32*(N+1) `rc_tick` strobes. N is bits [4:0] of offset 0x008, and no pulse comes earlier.
- R5: A new N written during a divider period takes effect only after the current period ends at its old length.
- R6: While the RC source is disabled, `iosc32_tick` stays low whatever `rc_tick` does.
- R7: `ext_tick` follows `xtal_tick` only while control bit 4 is 1. Otherwise it is low.
- R8: `osc32_tick` is the internal tick when control bit 0 is 0, and `ext_tick` when it is 1.
- R9: While bit 16 of offset 0x060 is 1, `ref32_tick` pulses once per 750 `ref_tick` strobes. While that bit is 0, `ref32_tick` is low.
- R10: `rtc_tick` follows `osc32_tick` when control bit 1 is 0, and `ref32_tick` when it is 1.
- R11: `fanout_tick` is low unless bit 0 of offset 0x060 is 1. When it is 1, bits [2:1] select the source: 0 the oscillator tick, 1 `alt_tick`, 2 the reference tick, 3 held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than every source strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rc_tick | input | 1 | One strobe per cycle of the internal 16 MHz RC source |
| xtal_tick | input | 1 | One strobe per cycle of the external 32 kHz crystal |
| ref_tick | input | 1 | One strobe per cycle of the 24 MHz reference |
| alt_tick | input | 1 | Strobe from the alternate 32 kHz input |
| iosc32_tick | output | 1 | Internal divided low-speed tick |
| ext_tick | output | 1 | Gated crystal tick |
| osc32_tick | output | 1 | Selected oscillator tick |
| ref32_tick | output | 1 | Reference divided by 750 |
| rtc_tick | output | 1 | Selected real-time tick |
| fanout_tick | output | 1 | Gated, selectable fanout tick |

## Verification
The assertions take three things for granted:
- Each source strobe is a level sampled on the system clock edge.
- Register writes are single-cycle.
- Several strobes may arrive in the same cycle.

The one-cycle latency of the divider outputs means a pulse may follow the disable of its source by exactly one cycle. The properties therefore relate each derived pulse to the enable one cycle earlier.

The stimulus changes the enables and the divider field only between bursts of strobes. It waits two cycles after an enable before sending strobes, so each stage is in `DIV_RUN` when counting starts. It lets pulses settle before counts are compared, except in the one test that deliberately rewrites N in the middle of a period.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 9'h000;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 9'h008;
    localparam logic [ADDR_W-1:0] OFS_GATE = 9'h060;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 9'h160;

    localparam logic [15:0] CTRL_KEY = 16'h16AA;

    typedef enum logic [1:0] {
        FAN_OSC = 2'd0,
        FAN_ALT = 2'd1,
        FAN_REF = 2'd2,
        FAN_OFF = 2'd3
    } fan_sel_e;

    typedef struct packed {
        logic     osc_pick_ext;
        logic     rtc_pick_ref;
        logic     xtal_pass;
        logic     ref_gate;
        logic     fan_en;
        fan_sel_e fan_sel;
        logic     rc_en;
        logic [4:0] div_n;
    } lsclk_cfg_t;
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
    import lsclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output lsclk_cfg_t        cfg
);
    logic [15:0]       ctrl_q;
    logic [DATA_W-1:0] div_q;
    logic [DATA_W-1:0] gate_q;
    logic [DATA_W-1:0] src_q;
    logic              key_ok;

    assign key_ok = (wdata[31:16] == CTRL_KEY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
            gate_q <= '0;
            src_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_CTRL: if (key_ok) ctrl_q <= wdata[15:0];
                OFS_DIV:  div_q  <= wdata;
                OFS_GATE: gate_q <= wdata;
                OFS_SRC:  src_q  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CTRL: rdata = {16'h0000, ctrl_q};
            OFS_DIV:  rdata = div_q;
            OFS_GATE: rdata = gate_q;
            OFS_SRC:  rdata = src_q;
            default:  rdata = '0;
        endcase
    end

    always_comb begin
        cfg.osc_pick_ext = ctrl_q[0];
        cfg.rtc_pick_ref = ctrl_q[1];
        cfg.xtal_pass    = ctrl_q[4];
        cfg.div_n        = div_q[4:0];
        cfg.fan_en       = gate_q[0];
        cfg.fan_sel      = fan_sel_e'(gate_q[2:1]);
        cfg.ref_gate     = gate_q[16];
        cfg.rc_en        = src_q[0];
    end
endmodule

// File: rtl/lsclk_tickdiv.sv
module lsclk_tickdiv #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick_in,
    input  logic [CNT_W-1:0] limit,
    output logic             tick_out
);
    typedef enum logic {DIV_IDLE, DIV_RUN} div_state_e;

    div_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic             term;

    assign term = (state_q == DIV_RUN) && en && tick_in && (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            DIV_IDLE: if (en)  state_nx = DIV_RUN;
            DIV_RUN:  if (!en) state_nx = DIV_IDLE;
            default:           state_nx = DIV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            lim_q    <= '0;
            tick_out <= 1'b0;
        end else begin
            tick_out <= term;
            if (state_q == DIV_IDLE || !en) begin
                cnt_q <= '0;
                lim_q <= limit;
            end else if (tick_in) begin
                if (cnt_q == lim_q) begin
                    cnt_q <= '0;
                    lim_q <= limit;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lsclk_sel.sv
module lsclk_sel
    import lsclk_pkg::*;
#(
    parameter int RC_PRE  = 32,
    parameter int REF_DIV = 750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rc_tick,
    input  logic              xtal_tick,
    input  logic              ref_tick,
    input  logic              alt_tick,
    output logic              iosc32_tick,
    output logic              ext_tick,
    output logic              osc32_tick,
    output logic              ref32_tick,
    output logic              rtc_tick,
    output logic              fanout_tick
);
    localparam int PRE_W = $clog2(RC_PRE);
    localparam int REF_W = $clog2(REF_DIV);
    localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(RC_PRE - 1);
    localparam logic [REF_W-1:0] REF_LIM = REF_W'(REF_DIV - 1);

    lsclk_cfg_t cfg;
    logic       pre_tick;
    logic       fan_src;

    lsclk_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg   (cfg)
    );

    lsclk_tickdiv #(.CNT_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.rc_en),
        .tick_in  (rc_tick),
        .limit    (PRE_LIM),
        .tick_out (pre_tick)
    );

    lsclk_tickdiv #(.CNT_W(5)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.rc_en),
        .tick_in  (pre_tick),
        .limit    (cfg.div_n),
        .tick_out (iosc32_tick)
    );

    lsclk_tickdiv #(.CNT_W(REF_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.ref_gate),
        .tick_in  (ref_tick),
        .limit    (REF_LIM),
        .tick_out (ref32_tick)
    );

    assign ext_tick   = xtal_tick & cfg.xtal_pass;
    assign osc32_tick = cfg.osc_pick_ext ? ext_tick : iosc32_tick;
    assign rtc_tick   = cfg.rtc_pick_ref ? ref32_tick : osc32_tick;

    always_comb begin
        unique case (cfg.fan_sel)
            FAN_OSC: fan_src = osc32_tick;
            FAN_ALT: fan_src = alt_tick;
            FAN_REF: fan_src = ref32_tick;
            default: fan_src = 1'b0;
        endcase
    end

    assign fanout_tick = cfg.fan_en & fan_src;
endmodule

// File: rtl/lsclk_sel_chk.sv
module lsclk_sel_chk
    import lsclk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rc_en,
    input logic              ref_gate,
    input logic              fan_en,
    input logic              xtal_tick,
    input logic              iosc32_tick,
    input logic              ext_tick,
    input logic              ref32_tick,
    input logic              fanout_tick
);
    // R2
    key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL && wdata[31:16] != CTRL_KEY && !$past(wr_en) && addr == $past(addr))
        |=> (addr != OFS_CTRL) || $stable(rdata));

    // R6
    rc_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iosc32_tick |-> $past(rc_en));

    // R9
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref32_tick |-> $past(ref_gate));

    // R11
    fan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fanout_tick |-> fan_en);

    // R7
    ext_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |-> xtal_tick);

    // R4
    iosc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iosc32_tick |=> !iosc32_tick);
endmodule

bind lsclk_sel lsclk_sel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rc_en       (cfg.rc_en),
    .ref_gate    (cfg.ref_gate),
    .fan_en      (cfg.fan_en),
    .xtal_tick   (xtal_tick),
    .iosc32_tick (iosc32_tick),
    .ext_tick    (ext_tick),
    .ref32_tick  (ref32_tick),
    .fanout_tick (fanout_tick)
);

// File: tb/lsclk_sel_tb.sv
module lsclk_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rc_tick = 1'b0, xtal_tick = 1'b0, ref_tick = 1'b0, alt_tick = 1'b0;
    logic        iosc32_tick, ext_tick, osc32_tick, ref32_tick, rtc_tick, fanout_tick;

    int n_chk = 0;
    int n_bad = 0;
    int c_iosc = 0, c_ext = 0, c_osc = 0, c_ref = 0, c_rtc = 0, c_fan = 0;
    bit clr = 1'b0;

    always #5 clk = ~clk;

    lsclk_sel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rc_tick(rc_tick), .xtal_tick(xtal_tick), .ref_tick(ref_tick), .alt_tick(alt_tick),
        .iosc32_tick(iosc32_tick), .ext_tick(ext_tick), .osc32_tick(osc32_tick),
        .ref32_tick(ref32_tick), .rtc_tick(rtc_tick), .fanout_tick(fanout_tick)
    );

    always @(negedge clk) begin
        if (clr) begin
            c_iosc = 0; c_ext = 0; c_osc = 0; c_ref = 0; c_rtc = 0; c_fan = 0;
        end else begin
            c_iosc += int'(iosc32_tick);
            c_ext  += int'(ext_tick);
            c_osc  += int'(osc32_tick);
            c_ref  += int'(ref32_tick);
            c_rtc  += int'(rtc_tick);
            c_fan  += int'(fanout_tick);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic zero();
        @(posedge clk); #1 clr = 1'b1;
        @(posedge clk); #1 clr = 1'b0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output int v);
        @(posedge clk); #1 addr = a;
        #3 v = int'(rdata);
    endtask

    task automatic feed_rc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 rc_tick = 1'b1;
        end
        @(posedge clk); #1 rc_tick = 1'b0;
    endtask

    task automatic feed_ref(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 ref_tick = 1'b1;
        end
        @(posedge clk); #1 ref_tick = 1'b0;
    endtask

    task automatic pulse_x(input int n, input bit alt);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (alt) alt_tick = 1'b1; else xtal_tick = 1'b1;
            @(posedge clk); #1;
            alt_tick = 1'b0; xtal_tick = 1'b0;
        end
    endtask

    initial begin
        #1500000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int v;
        idle(3);
        rst_n = 1'b1;
        zero();

        // R1: reset state
        rd(9'h000, v); check("R1 ctrl", v, 0);
        rd(9'h008, v); check("R1 div", v, 0);
        rd(9'h060, v); check("R1 gate", v, 0);
        rd(9'h160, v); check("R1 src", v, 0);
        feed_rc(100); pulse_x(3, 0); feed_ref(800);
        idle(4);
        check("R1 quiet", c_iosc + c_ext + c_ref + c_rtc + c_fan, 0);
        // R6: source disabled, strobes ignored
        check("R6 iosc low", c_iosc, 0);

        // R2/R3: key handling
        wr(9'h000, 32'h1234_0013);
        rd(9'h000, v); check("R2 no key", v, 0);
        wr(9'h000, 32'h16AA_0013);
        rd(9'h000, v); check("R3 keyed readback", v, 32'h13);
        wr(9'h000, 32'h16AB_0000);
        rd(9'h000, v); check("R2 wrong key", v, 32'h13);
        wr(9'h000, 32'h16AA_0000);

        // R4 + R10: exhaustive sweep of N
        for (int n = 0; n < 32; n++) begin
            int per;
            per = 32 * (n + 1);
            wr(9'h160, 0);
            wr(9'h008, n);
            wr(9'h160, 1);
            idle(2);
            zero();
            feed_rc(per - 1); idle(4);
            check($sformatf("R4 early N=%0d", n), c_iosc, 0);
            feed_rc(1); idle(4);
            check($sformatf("R4 first N=%0d", n), c_iosc, 1);
            feed_rc(per); idle(4);
            check($sformatf("R4 second N=%0d", n), c_iosc, 2);
            check($sformatf("R10 rtc follows N=%0d", n), c_rtc, 2);
        end

        // R5: mid-period change of N
        wr(9'h160, 0); wr(9'h008, 1); wr(9'h160, 1); idle(2); zero();
        feed_rc(32);
        wr(9'h008, 3);
        feed_rc(32); idle(4);
        check("R5 old period", c_iosc, 1);
        feed_rc(127); idle(4);
        check("R5 new period early", c_iosc, 1);
        feed_rc(1); idle(4);
        check("R5 new period", c_iosc, 2);

        // R6: disable mid-stream
        wr(9'h160, 0); zero();
        feed_rc(300); idle(4);
        check("R6 disabled", c_iosc, 0);

        // R7/R8: crystal gating and oscillator select
        wr(9'h000, 32'h16AA_0011); zero();
        pulse_x(5, 0); idle(3);
        check("R7 ext pass", c_ext, 5);
        check("R8 osc ext", c_osc, 5);
        check("R10 rtc osc", c_rtc, 5);
        wr(9'h000, 32'h16AA_0001); zero();
        pulse_x(4, 0); idle(3);
        check("R7 ext blocked", c_ext, 0);
        check("R8 osc ext blocked", c_osc, 0);

        // R9: reference divider
        wr(9'h060, 32'h0001_0000); idle(2); zero();
        feed_ref(749); idle(4);
        check("R9 early", c_ref, 0);
        feed_ref(751); idle(4);
        check("R9 two", c_ref, 2);
        wr(9'h060, 0); zero();
        feed_ref(800); idle(4);
        check("R9 gated", c_ref, 0);

        // R10: rtc from reference
        wr(9'h000, 32'h16AA_0002);
        wr(9'h060, 32'h0001_0000); idle(2); zero();
        feed_ref(750); idle(4);
        check("R10 rtc ref", c_rtc, 1);

        // R11: fanout
        wr(9'h060, 32'h0000_0003); zero();
        pulse_x(3, 1); idle(3);
        check("R11 alt", c_fan, 3);
        wr(9'h060, 32'h0000_0007); zero();
        pulse_x(3, 1); idle(3);
        check("R11 sel3 low", c_fan, 0);
        wr(9'h060, 32'h0000_0002); zero();
        pulse_x(3, 1); idle(3);
        check("R11 disabled", c_fan, 0);
        wr(9'h060, 32'h0001_0005); idle(2); zero();
        feed_ref(750); idle(4);
        check("R11 ref", c_fan, 1);
        wr(9'h000, 32'h16AA_0011);
        wr(9'h060, 32'h0000_0001); zero();
        pulse_x(2, 0); idle(3);
        check("R11 osc", c_fan, 2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule